// File: doc/BRIEF.md
# Fault-Aware Torus Route Selector

This block is the route computation stage of a five-port wormhole router in a two-dimensional torus. Each header flit carries a signed hop count per dimension. The block picks an output port in dimension order: X first, then Y, then Local. It registers the header, possibly rewritten, together with the chosen port. Only headers pass through this stage. Payload and tail flits follow the path that the header opens.

A 10-bit channel-fault mask is loaded serially over a scan interface. It marks which input and output channels of the router are broken. Suppose the output that a header would take is marked broken and the opposite output in the same dimension is healthy. The block then sends the packet the other way around the ring and rewrites that dimension's hop count for the longer trip. If both outputs of the active dimension are broken, or the Local output is broken, rerouting cannot help. The block then keeps the original port and raises a split-mode flag for the link-repair logic downstream.

Header input and routed output are valid/ready streams. A header moves on a cycle where valid and ready are both high. A held output must not change while out_ready is low. The scan pins are plain control pins.

Top module: `torus_route_sel`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and all ten fault bits are 0.
- R2: The header is {dx, dy}. dx sits in the upper CW bits and dy in the lower CW bits, both two's complement. The port codes are Local=0, North=1, South=2, West=3, East=4. With no relevant fault, the port is chosen as follows:
  - dx>0 gives East and dx<0 gives West.
  - When dx=0, dy>0 gives North and dy<0 gives South.
  - When dx=0 and dy=0, the port is Local.
  - The header leaves unchanged with out_split=0.
- R3: Suppose the preferred output of the active dimension is faulty and the opposite output is healthy. The opposite port is chosen with out_split=0. The active count k becomes k−SIZE (if k>0) or k+SIZE (if k<0), where SIZE is that dimension's ring length. The other count is unchanged.
- R4: If both outputs of the active dimension are faulty, the preferred port is kept, out_split=1 and the header is unchanged.
- R5: A header with dx=0 and dy=0 goes to Local, with out_split equal to the Local output fault bit and the header unchanged.
- R6: Fault bits of the inactive dimension, and all input-channel fault bits, have no effect on the port, the flag or the header.
- R7: Fault bit p marks the output channel of port code p, and bit p+5 marks the input channel of port code p. While scan_en is high and the block is idle, each clock shifts the register one place toward bit 0. scan_in enters bit 9 and scan_out shows bit 0. A word loaded LSB first therefore lands in place after ten shifts, and the old word appears on scan_out LSB first.
- R8: Scan shifts are ignored while in_valid or out_valid is high.
- R9: in_ready equals (not out_valid) or out_ready. An accepted header appears on the outputs one cycle later. While out_valid is high and out_ready is low, all outputs hold.
- R10: A routed header with out_split=0 never names a port whose output fault bit is set. A routed header with out_split=1 always names one whose bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Shift enable for the fault register |
| scan_in | input | 1 | Serial fault data, LSB first |
| scan_out | output | 1 | Bit 0 of the fault register |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be taken |
| in_hdr | input | 2*CW | {dx, dy} signed hop counts |
| out_valid | output | 1 | Routed header present |
| out_ready | input | 1 | Downstream takes routed header |
| out_hdr | output | 2*CW | Possibly rewritten header |
| out_port | output | 3 | Chosen port code |
| out_split | output | 1 | Use split mode on the chosen port |

## Verification
The bench builds the block with an X ring of 3 and a Y ring of 4, which gives CW=3. The odd X ring makes each rewrite flip a count to a hop count of different size (2→−1). The even Y ring brings the extreme counts ±3 and their rewrites ∓1 into reach without overflowing the field. Random sparse fault masks are mixed with directed single, paired, Local and input-only faults. The bench reads the mask back through the scan chain to check loading and the ignore-while-busy rule.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_WEST  = 3'd3,
    PORT_EAST  = 3'd4
  } port_e;

  localparam int NUM_PORTS = 5;
  localparam int FAULT_BITS = 2 * NUM_PORTS;
endpackage

// File: rtl/fault_scan_reg.sv
module fault_scan_reg #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         sin,
  output logic [N-1:0] q,
  output logic         sout
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {sin, q[N-1:1]};
  end

  assign sout = q[0];

  // R7
  shift_enters_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> q[N-1] == $past(sin));
endmodule

// File: rtl/dim_pick.sv
module dim_pick #(
  parameter int SIZE = 4,
  parameter int CW   = 3
) (
  input  logic [CW-1:0] cnt,
  input  logic          pos_bad,
  input  logic          neg_bad,
  output logic          go_neg,
  output logic [CW-1:0] cnt_out,
  output logic          split
);
  localparam logic [CW-1:0] RING = CW'(SIZE);

  logic want_neg, want_bad, alt_bad;

  always_comb begin
    want_neg = cnt[CW-1];
    want_bad = want_neg ? neg_bad : pos_bad;
    alt_bad  = want_neg ? pos_bad : neg_bad;
    go_neg   = want_neg;
    cnt_out  = cnt;
    split    = 1'b0;
    if (want_bad) begin
      if (alt_bad) begin
        split = 1'b1;
      end else begin
        go_neg  = !want_neg;
        cnt_out = want_neg ? cnt + RING : cnt - RING;
      end
    end
  end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
  import torus_rt_pkg::*;
#(
  parameter int X_SIZE = 3,
  parameter int Y_SIZE = 4,
  localparam int MAXS  = (X_SIZE > Y_SIZE) ? X_SIZE : Y_SIZE,
  localparam int CW    = $clog2(MAXS) + 1,
  localparam int HDR_W = 2 * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [HDR_W-1:0] in_hdr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [HDR_W-1:0] out_hdr,
  output logic [2:0]       out_port,
  output logic             out_split
);
  logic [FAULT_BITS-1:0] fault_q;
  logic                  busy;

  assign busy     = in_valid || out_valid;
  assign in_ready = !out_valid || out_ready;

  fault_scan_reg #(.N(FAULT_BITS)) u_faults (
    .clk  (clk),
    .rst_n(rst_n),
    .shift(scan_en && !busy),
    .sin  (scan_in),
    .q    (fault_q),
    .sout (scan_out)
  );

  logic [CW-1:0] cnt   [2];
  logic [CW-1:0] newc  [2];
  logic          dneg  [2];
  logic          dsplit[2];

  assign cnt[0] = in_hdr[HDR_W-1:CW];
  assign cnt[1] = in_hdr[CW-1:0];

  for (genvar d = 0; d < 2; d++) begin : g_dim
    localparam int SZ = (d == 0) ? X_SIZE : Y_SIZE;
    localparam int PP = (d == 0) ? int'(PORT_EAST) : int'(PORT_NORTH);
    localparam int NP = (d == 0) ? int'(PORT_WEST) : int'(PORT_SOUTH);
    dim_pick #(.SIZE(SZ), .CW(CW)) u_pick (
      .cnt    (cnt[d]),
      .pos_bad(fault_q[PP]),
      .neg_bad(fault_q[NP]),
      .go_neg (dneg[d]),
      .cnt_out(newc[d]),
      .split  (dsplit[d])
    );
  end

  port_e            nx_port;
  logic             nx_split;
  logic [HDR_W-1:0] nx_hdr;

  always_comb begin
    if (cnt[0] != '0) begin
      nx_port  = dneg[0] ? PORT_WEST : PORT_EAST;
      nx_split = dsplit[0];
      nx_hdr   = {newc[0], cnt[1]};
    end else if (cnt[1] != '0) begin
      nx_port  = dneg[1] ? PORT_SOUTH : PORT_NORTH;
      nx_split = dsplit[1];
      nx_hdr   = {cnt[0], newc[1]};
    end else begin
      nx_port  = PORT_LOCAL;
      nx_split = fault_q[int'(PORT_LOCAL)];
      nx_hdr   = in_hdr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hdr   <= '0;
      out_port  <= PORT_LOCAL;
      out_split <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_hdr   <= nx_hdr;
      out_port  <= nx_port;
      out_split <= nx_split;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) &&
                                   $stable(out_port) && $stable(out_split)));

  // R8
  scan_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && busy) |=> fault_q == $past(fault_q));

  // R10
  clean_port_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_split) |-> !fault_q[out_port]);

  // R10
  split_port_faulty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_split) |-> fault_q[out_port]);

  // R2
  local_zero_hops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_port == PORT_LOCAL) |-> out_hdr == '0);
endmodule

// File: tb/torus_route_sel_test.sv
`timescale 1ns/1ps
module torus_route_sel_test;
  localparam int XS = 3;
  localparam int YS = 4;
  localparam int CW = 3;
  localparam int HW = 2 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0, scan_in = 1'b0, scan_out;
  logic in_valid = 1'b0, in_ready;
  logic [HW-1:0] in_hdr = '0;
  logic out_valid, out_ready = 1'b1;
  logic [HW-1:0] out_hdr;
  logic [2:0] out_port;
  logic out_split;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  torus_route_sel #(.X_SIZE(XS), .Y_SIZE(YS)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_port(out_port), .out_split(out_split)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [CW-1:0] v);
    logic signed [CW-1:0] s;
    s = v;
    return int'(s);
  endfunction

  function automatic void model(input int dx, input int dy, input logic [9:0] m,
                                output int ep, output bit es, output int ndx, output int ndy);
    ndx = dx; ndy = dy; es = 1'b0;
    if (dx != 0) begin
      ep = (dx > 0) ? 4 : 3;
      if (m[ep]) begin
        if (m[7 - ep]) es = 1'b1;
        else begin ep = 7 - ep; ndx = (dx > 0) ? dx - XS : dx + XS; end
      end
    end else if (dy != 0) begin
      ep = (dy > 0) ? 1 : 2;
      if (m[ep]) begin
        if (m[3 - ep]) es = 1'b1;
        else begin ep = 3 - ep; ndy = (dy > 0) ? dy - YS : dy + YS; end
      end
    end else begin
      ep = 0; es = m[0];
    end
  endfunction

  task automatic scan_xfer(input logic [9:0] w, output logic [9:0] r);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      scan_en = 1'b1; scan_in = w[i]; r[i] = scan_out;
    end
    @(negedge clk);
    scan_en = 1'b0;
  endtask

  task automatic load_mask(input logic [9:0] w);
    logic [9:0] junk;
    scan_xfer(w, junk);
  endtask

  task automatic send(input int dx, input int dy, input logic [9:0] m,
                      input int hold, input string req);
    int ep, ndx, ndy;
    bit es;
    model(dx, dy, m, ep, es, ndx, ndy);
    @(negedge clk);
    in_valid = 1'b1; in_hdr = {CW'(dx), CW'(dy)}; out_ready = (hold == 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {req, " R9 valid"}, int'(out_valid), 1);
    chk(int'(out_port) == ep, {req, " port"}, int'(out_port), ep);
    chk(out_split == es, {req, " split"}, int'(out_split), int'(es));
    chk(sx(out_hdr[HW-1:CW]) == ndx, {req, " dx"}, sx(out_hdr[HW-1:CW]), ndx);
    chk(sx(out_hdr[CW-1:0]) == ndy, {req, " dy"}, sx(out_hdr[CW-1:0]), ndy);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && int'(out_port) == ep && in_ready == 1'b0, "R9 hold",
          int'(out_port), ep);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drain", int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] rd, m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    scan_xfer(10'h000, rd);
    chk(rd == 10'h000, "R1 mask", int'(rd), 0);

    // R2 fault-free XY order
    send(2, 1, 10'h000, 0, "R2 east");
    send(-1, 3, 10'h000, 0, "R2 west");
    send(0, -2, 10'h000, 0, "R2 south");
    send(0, 3, 10'h000, 1, "R2 north");
    send(0, 0, 10'h000, 0, "R2 local");

    // R7 load and readback
    load_mask(10'h2A5);
    scan_xfer(10'h010, rd);
    chk(rd == 10'h2A5, "R7 readback", int'(rd), 10'h2A5);

    // R3 east faulty reroutes west; R6 other dimension unaffected
    send(2, 1, 10'h010, 0, "R3 east->west");
    send(-2, 0, 10'h010, 0, "R6 west unaffected");
    send(0, 2, 10'h010, 0, "R6 Y unaffected");
    load_mask(10'h008);
    send(-2, -3, 10'h008, 2, "R3 west->east");
    load_mask(10'h002);
    send(0, 3, 10'h002, 0, "R3 north->south");
    send(0, -3, 10'h002, 0, "R6 south unaffected");
    load_mask(10'h004);
    send(0, -3, 10'h004, 0, "R3 south->north");

    // R4 both in dimension faulty
    load_mask(10'h018);
    send(1, 0, 10'h018, 0, "R4 X pair");
    send(0, -1, 10'h018, 0, "R6 X pair Y ok");
    load_mask(10'h006);
    send(0, 2, 10'h006, 0, "R4 Y pair");

    // R5 local fault
    load_mask(10'h001);
    send(0, 0, 10'h001, 0, "R5 local split");
    send(1, 1, 10'h001, 0, "R6 local bit X");

    // R6 input-channel bits only
    load_mask(10'h3E0);
    send(1, -1, 10'h3E0, 0, "R6 input bits");
    send(0, 0, 10'h3E0, 0, "R6 input local");

    // R8 scan ignored while busy
    load_mask(10'h011);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_hdr = {CW'(1), CW'(0)};
    @(negedge clk);
    in_valid = 1'b0;
    scan_xfer(10'h3FF, rd);
    chk(out_valid == 1'b1 && out_port == 3'd3, "R8 held output", int'(out_port), 3);
    out_ready = 1'b1;
    @(negedge clk);
    scan_xfer(10'h011, rd);
    chk(rd == 10'h011, "R8 mask unchanged", int'(rd), 10'h011);

    // random phase
    m = 10'h011;
    for (int it = 0; it < 300; it++) begin
      if (it % 15 == 0) begin
        m = 10'($urandom & $urandom);
        load_mask(m);
      end
      send(int'($urandom_range(0, 4)) - 2, int'($urandom_range(0, 6)) - 3, m,
           int'($urandom_range(0, 2)), "R2/R3/R4/R5/R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule